// File: doc/BRIEF.md
# I2C Transmit Byte Queue with Output Holding Register

This block sits between the register-write side of an I2C controller and its bit-level transmit engine. Software pushes bytes into a two-entry queue, either one at a time or two in a single write. A separate holding register presents the oldest byte to the engine. The engine reports when it starts a byte and when it has finished one. When a byte finishes, the next queued byte moves into the holding register on the same clock edge.

The block also produces three kinds of flag. The first is a buffer-level flag with two selectable thresholds. The second is a transmit-complete pair: a status bit plus a sticky interrupt bit. The third is a sticky overflow interrupt, raised when a write needs more room than is free; such a write stores nothing. A clear command empties the queue and drops a byte that is held but not yet started. A byte already being sent runs to completion, and the transmit-complete flags wait for it.

Top module: `i2c_tx_buffer`

## Requirements
- R1: After reset the engine sees no byte, the level flag is high, and the transmit-complete status, transmit-complete interrupt and overflow interrupt are all low.
- R2: A single write stores `wr_data_i[7:0]`. If the holding register is empty, the byte appears on `eng_byte_o` with `eng_valid_o` high one edge after the edge that stored it.
- R3: A double write stores `wr_data_i[7:0]` first and `wr_data_i[15:8]` second. If single and double writes are asserted together, the double write is performed.
- R4: A held byte stays unchanged on the engine port until `eng_done_i` arrives for that byte after `eng_start_i`. On that same edge the oldest queued byte, if any, is loaded.
- R5: `eng_start_i` is ignored when no byte is held. `eng_done_i` is ignored when the held byte has not been started.
- R6: With `lvl_half_i` low, `lvl_ok_o` is high only when the queue is empty. With it high, `lvl_ok_o` is high when the queue holds at most one byte. The flag follows the queue level without any software clear.
- R7: A write needing more slots than are free sets `ovf_irq_o` and stores no byte at all, so a double write with one free slot stores neither byte. `ovf_irq_o` stays set until `clr_ovf_i`. If a set and a clear occur together, the set wins.
- R8: A slot freed by a reload on the same edge counts as free space for a write on that edge.
- R9: When a finished byte leaves both the queue and the holding register empty, `txc_sts_o` and `txc_irq_o` are set on that edge. `txc_sts_o` falls on the edge of the next accepted write. `txc_irq_o` stays set until `clr_txc_i`.
- R10: `clear_i` empties the queue and drops a held byte that has not been started. A started byte stays on the port until its done. Transmit-complete is raised at that done, never while the byte is still in flight.
- R11: A write in the same cycle as `clear_i` is stored into the emptied queue and cannot overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_single_i | input | 1 | Push the low byte of `wr_data_i` |
| wr_double_i | input | 1 | Push both bytes of `wr_data_i`, low byte first |
| wr_data_i | input | 16 | Write data |
| clear_i | input | 1 | Flush queue and any unstarted held byte |
| lvl_half_i | input | 1 | Level threshold select (0: empty, 1: at most one) |
| clr_txc_i | input | 1 | Clear transmit-complete interrupt |
| clr_ovf_i | input | 1 | Clear overflow interrupt |
| eng_start_i | input | 1 | Engine has begun sending the held byte |
| eng_done_i | input | 1 | Engine has finished the started byte |
| eng_valid_o | output | 1 | A byte is held for the engine |
| eng_byte_o | output | 8 | Held byte |
| lvl_ok_o | output | 1 | Buffer-level flag |
| txc_sts_o | output | 1 | Transmit-complete status |
| txc_irq_o | output | 1 | Transmit-complete interrupt (sticky) |
| ovf_irq_o | output | 1 | Overflow interrupt (sticky) |

## Verification
A write changes the queue level and `lvl_ok_o` on the edge that samples it. Overflow, transmit-complete and the engine-side reload also land on the sampling edge of their cause. A byte written into an empty path needs one further edge before `eng_valid_o` rises. `lvl_ok_o` also responds combinationally to `lvl_half_i`. Every scenario task drives its inputs just after an edge and reads the outputs 1 ns after the following edge. Each check is therefore placed on the exact edge where the register chain makes the result due.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
  // Number of bytes a write pushes into the queue
  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_e;
endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo
  import txq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  push_e         push,
  input  logic [W-1:0]  lo,
  input  logic [W-1:0]  hi,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  head
);
  localparam int FW = CW + 1;

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [DEPTH-1:0][W-1:0] mem_d;
  logic [CW-1:0]           cnt_q;
  logic [CW-1:0]           cnt_d;
  logic [FW-1:0]           base;
  logic                    mem_en;
  logic                    cnt_en;

  // Slot index where the first pushed byte lands, after flush and pop
  always_comb begin
    base   = flush ? '0 : (FW'(cnt_q) - FW'(pop));
    cnt_d  = CW'(base + FW'(push));
    cnt_en = flush | pop | (push != PUSH_NONE);
    mem_en = pop | (push != PUSH_NONE);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (pop && !flush && (i < DEPTH - 1)) begin
        mem_d[i] = mem_q[(i + 1) % DEPTH];
      end
      if ((push != PUSH_NONE) && (base == FW'(i))) begin
        mem_d[i] = lo;
      end
      if ((push == PUSH_TWO) && ((base + FW'(1)) == FW'(i))) begin
        mem_d[i] = hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Data storage carries no reset
  always_ff @(posedge clk) begin
    if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  assign cnt  = cnt_q;
  assign head = mem_q[0];
endmodule

// File: rtl/txq_shifter.sv
`timescale 1ns/1ps
module txq_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         start,
  input  logic         done,
  input  logic         drop,
  output logic         vld,
  output logic         busy,
  output logic [W-1:0] data,
  output logic         start_ok,
  output logic         done_ok
);
  logic         vld_q, vld_d;
  logic         busy_q, busy_d;
  logic [W-1:0] data_q;
  logic         st_en;

  always_comb begin
    start_ok = start & vld_q & ~busy_q;
    done_ok  = done & busy_q;
    vld_d    = vld_q;
    busy_d   = busy_q;
    if (start_ok) begin
      busy_d = 1'b1;
    end
    if (done_ok) begin
      vld_d  = 1'b0;
      busy_d = 1'b0;
    end
    if (drop) begin
      vld_d = 1'b0;
    end
    if (load) begin
      vld_d  = 1'b1;
      busy_d = 1'b0;
    end
    st_en = start_ok | done_ok | drop | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (st_en) begin
      vld_q  <= vld_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= ld_data;
    end
  end

  assign vld  = vld_q;
  assign busy = busy_q;
  assign data = data_q;
endmodule

// File: rtl/txq_ctrl.sv
`timescale 1ns/1ps
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_single,
  input  logic          wr_double,
  input  logic          clear,
  input  logic          lvl_half,
  input  logic          clr_txc,
  input  logic          clr_ovf,
  input  logic [CW-1:0] cnt,
  input  logic          sh_vld,
  input  logic          sh_busy,
  input  logic          start_ok,
  input  logic          done_ok,
  output logic          reload,
  output logic          drop,
  output logic          flush,
  output push_e         push,
  output logic          lvl_ok,
  output logic          txc_sts,
  output logic          txc_irq,
  output logic          ovf_irq
);
  localparam int FW = CW + 1;

  logic [FW-1:0] free;
  logic [FW-1:0] need;
  logic [FW-1:0] cnt_after;
  logic          sh_room;
  logic          accept;
  logic          reject;
  logic          txc_evt;

  logic txc_sts_q, txc_sts_d, txc_sts_en;
  logic txc_irq_q, txc_irq_d, txc_irq_en;
  logic ovf_q, ovf_d, ovf_en;

  // Queue and holding-register sequencing
  always_comb begin
    sh_room   = ~sh_vld | done_ok;
    reload    = ~clear & sh_room & (cnt != '0);
    drop      = clear & sh_vld & ~sh_busy & ~start_ok;
    flush     = clear;
    free      = clear ? FW'(DEPTH) : (FW'(DEPTH) - FW'(cnt) + FW'(reload));
    need      = wr_double ? FW'(2) : (wr_single ? FW'(1) : '0);
    accept    = (need != '0) && (need <= free);
    reject    = (need != '0) && (need > free);
    push      = !accept ? PUSH_NONE : (wr_double ? PUSH_TWO : PUSH_ONE);
    cnt_after = (clear ? '0 : (FW'(cnt) - FW'(reload))) + (accept ? need : '0);
    txc_evt   = done_ok & ~reload & (cnt_after == '0);
    lvl_ok    = lvl_half ? (cnt <= CW'(1)) : (cnt == '0);
  end

  // Flag next-state
  always_comb begin
    txc_sts_d  = txc_evt;
    txc_sts_en = txc_evt | accept;
    txc_irq_d  = txc_evt;
    txc_irq_en = txc_evt | clr_txc;
    ovf_d      = reject;
    ovf_en     = reject | clr_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_sts_q <= 1'b0;
      txc_irq_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (txc_sts_en) begin
        txc_sts_q <= txc_sts_d;
      end
      if (txc_irq_en) begin
        txc_irq_q <= txc_irq_d;
      end
      if (ovf_en) begin
        ovf_q <= ovf_d;
      end
    end
  end

  assign txc_sts = txc_sts_q;
  assign txc_irq = txc_irq_q;
  assign ovf_irq = ovf_q;
endmodule

// File: rtl/i2c_tx_buffer.sv
`timescale 1ns/1ps
module i2c_tx_buffer
  import txq_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_single_i,
  input  logic         wr_double_i,
  input  logic [2*W-1:0] wr_data_i,
  input  logic         clear_i,
  input  logic         lvl_half_i,
  input  logic         clr_txc_i,
  input  logic         clr_ovf_i,
  input  logic         eng_start_i,
  input  logic         eng_done_i,
  output logic         eng_valid_o,
  output logic [W-1:0] eng_byte_o,
  output logic         lvl_ok_o,
  output logic         txc_sts_o,
  output logic         txc_irq_o,
  output logic         ovf_irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [CW-1:0] fifo_cnt;
  logic [W-1:0]  fifo_head;
  logic          reload;
  logic          drop;
  logic          flush;
  push_e         push;
  logic          sh_vld;
  logic          sh_busy;
  logic          start_ok;
  logic          done_ok;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  txq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .flush (flush),
    .pop   (reload),
    .push  (push),
    .lo    (wr_data_i[W-1:0]),
    .hi    (wr_data_i[2*W-1:W]),
    .cnt   (fifo_cnt),
    .head  (fifo_head)
  );

  txq_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (reload),
    .ld_data  (fifo_head),
    .start    (eng_start_i),
    .done     (eng_done_i),
    .drop     (drop),
    .vld      (sh_vld),
    .busy     (sh_busy),
    .data     (eng_byte_o),
    .start_ok (start_ok),
    .done_ok  (done_ok)
  );

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_single (wr_single_i),
    .wr_double (wr_double_i),
    .clear     (clear_i),
    .lvl_half  (lvl_half_i),
    .clr_txc   (clr_txc_i),
    .clr_ovf   (clr_ovf_i),
    .cnt       (fifo_cnt),
    .sh_vld    (sh_vld),
    .sh_busy   (sh_busy),
    .start_ok  (start_ok),
    .done_ok   (done_ok),
    .reload    (reload),
    .drop      (drop),
    .flush     (flush),
    .push      (push),
    .lvl_ok    (lvl_ok_o),
    .txc_sts   (txc_sts_o),
    .txc_irq   (txc_irq_o),
    .ovf_irq   (ovf_irq_o)
  );

  assign eng_valid_o = sh_vld;
endmodule

// File: rtl/txq_checker.sv
`timescale 1ns/1ps
module txq_checker #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_single_i,
  input logic          wr_double_i,
  input logic          clear_i,
  input logic          eng_done_i,
  input logic          clr_txc_i,
  input logic          clr_ovf_i,
  input logic          eng_valid_o,
  input logic [W-1:0]  eng_byte_o,
  input logic          txc_sts_o,
  input logic          txc_irq_o,
  input logic          ovf_irq_o,
  input logic [CW-1:0] cnt,
  input logic          sh_busy
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R7

  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_single_i | wr_double_i) && cnt == CW'(DEPTH) && eng_valid_o && !eng_done_i && !clear_i)
    |=> (ovf_irq_o && cnt == CW'(DEPTH))); // R7

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq_o && !clr_ovf_i) |=> ovf_irq_o); // R7

  AST_TXC_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_single_i && !wr_double_i && cnt == '0 && !clear_i) |=> !txc_sts_o); // R9

  AST_TXC_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_irq_o && !clr_txc_i) |=> txc_irq_o); // R9

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid_o && !eng_done_i && !clear_i) |=> (eng_valid_o && $stable(eng_byte_o))); // R4

  AST_INFLIGHT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && sh_busy && !eng_done_i) |=> (eng_valid_o && $stable(eng_byte_o))); // R10

  AST_NO_TXC_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !txc_sts_o); // R10
endmodule

bind i2c_tx_buffer txq_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_single_i (wr_single_i),
  .wr_double_i (wr_double_i),
  .clear_i     (clear_i),
  .eng_done_i  (eng_done_i),
  .clr_txc_i   (clr_txc_i),
  .clr_ovf_i   (clr_ovf_i),
  .eng_valid_o (eng_valid_o),
  .eng_byte_o  (eng_byte_o),
  .txc_sts_o   (txc_sts_o),
  .txc_irq_o   (txc_irq_o),
  .ovf_irq_o   (ovf_irq_o),
  .cnt         (fifo_cnt),
  .sh_busy     (sh_busy)
);

// File: tb/tb_i2c_tx_buffer.sv
`timescale 1ns/1ps
module tb_i2c_tx_buffer;
  logic        clk;
  logic        rst_n;
  logic        wr_single_i, wr_double_i, clear_i, lvl_half_i;
  logic        clr_txc_i, clr_ovf_i, eng_start_i, eng_done_i;
  logic [15:0] wr_data_i;
  logic        eng_valid_o, lvl_ok_o, txc_sts_o, txc_irq_o, ovf_irq_o;
  logic [7:0]  eng_byte_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  i2c_tx_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .wr_single_i(wr_single_i), .wr_double_i(wr_double_i), .wr_data_i(wr_data_i),
    .clear_i(clear_i), .lvl_half_i(lvl_half_i),
    .clr_txc_i(clr_txc_i), .clr_ovf_i(clr_ovf_i),
    .eng_start_i(eng_start_i), .eng_done_i(eng_done_i),
    .eng_valid_o(eng_valid_o), .eng_byte_o(eng_byte_o), .lvl_ok_o(lvl_ok_o),
    .txc_sts_o(txc_sts_o), .txc_irq_o(txc_irq_o), .ovf_irq_o(ovf_irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One edge, then release all pulse inputs 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
    wr_single_i = 0; wr_double_i = 0; clear_i = 0;
    clr_txc_i = 0; clr_ovf_i = 0; eng_start_i = 0; eng_done_i = 0;
  endtask

  task automatic wr1(input logic [7:0] b);
    wr_single_i = 1; wr_data_i = {8'h00, b}; tick();
  endtask

  task automatic wr2(input logic [15:0] d);
    wr_double_i = 1; wr_data_i = d; tick();
  endtask

  // Start then finish the held byte
  task automatic send();
    eng_start_i = 1; tick();
    eng_done_i = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1", "valid", eng_valid_o, 0);
    chk("R1", "lvl", lvl_ok_o, 1);
    chk("R1", "txc_sts", txc_sts_o, 0);
    chk("R1", "txc_irq", txc_irq_o, 0);
    chk("R1", "ovf", ovf_irq_o, 0);
    eng_done_i = 1; tick();
    eng_start_i = 1; tick();
    chk("R5", "done ignored sts", txc_sts_o, 0);
    chk("R5", "done ignored irq", txc_irq_o, 0);
    chk("R5", "start ignored valid", eng_valid_o, 0);
  endtask

  task automatic t_single();
    wr1(8'h11);
    chk("R2", "valid after write", eng_valid_o, 0);
    chk("R6", "lvl empty-mode one byte", lvl_ok_o, 0);
    lvl_half_i = 1; #1;
    chk("R6", "lvl half-mode one byte", lvl_ok_o, 1);
    lvl_half_i = 0; #1;
    tick();
    chk("R2", "valid loaded", eng_valid_o, 1);
    chk("R2", "byte loaded", eng_byte_o, 16'h11);
    chk("R6", "lvl empty", lvl_ok_o, 1);
    eng_done_i = 1; tick();
    chk("R5", "done before start valid", eng_valid_o, 1);
    chk("R5", "done before start byte", eng_byte_o, 16'h11);
  endtask

  task automatic t_double();
    wr2(16'h3322);
    lvl_half_i = 1; #1;
    chk("R6", "lvl half-mode full", lvl_ok_o, 0);
    wr1(8'h44);
    chk("R7", "ovf set", ovf_irq_o, 1);
    chk("R4", "byte held", eng_byte_o, 16'h11);
    send();
    chk("R3", "low byte first", eng_byte_o, 16'h22);
    chk("R6", "lvl half-mode one", lvl_ok_o, 1);
    send();
    chk("R3", "high byte second", eng_byte_o, 16'h33);
    chk("R9", "no txc yet", txc_sts_o, 0);
    send();
    chk("R7", "rejected byte absent", eng_valid_o, 0);
    chk("R9", "txc sts", txc_sts_o, 1);
    chk("R9", "txc irq", txc_irq_o, 1);
    clr_ovf_i = 1; tick();
    chk("R7", "ovf cleared", ovf_irq_o, 0);
    lvl_half_i = 0;
  endtask

  task automatic t_partial();
    wr1(8'h55);
    chk("R9", "sts falls on write", txc_sts_o, 0);
    chk("R9", "irq sticky", txc_irq_o, 1);
    tick();
    wr1(8'h66);
    wr2(16'h8877);
    chk("R7", "ovf on double one slot", ovf_irq_o, 1);
    clr_ovf_i = 1; wr2(16'h8877);
    chk("R7", "set wins over clear", ovf_irq_o, 1);
    send();
    chk("R7", "old entry kept", eng_byte_o, 16'h66);
    send();
    chk("R7", "neither byte stored", eng_valid_o, 0);
    clr_txc_i = 1; tick();
    chk("R9", "irq cleared", txc_irq_o, 0);
    clr_ovf_i = 1; tick();
  endtask

  task automatic t_done_write();
    wr2(16'hA2A1);
    tick();
    wr1(8'hA3);
    eng_start_i = 1; tick();
    eng_done_i = 1; wr_single_i = 1; wr_data_i = 16'h00A4; tick();
    chk("R8", "no ovf with reload", ovf_irq_o, 0);
    chk("R4", "reload same edge", eng_byte_o, 16'hA2);
    chk("R8", "queue full", lvl_ok_o, 0);
    send();
    chk("R8", "third byte", eng_byte_o, 16'hA3);
    send();
    chk("R8", "fourth byte", eng_byte_o, 16'hA4);
    send();
    chk("R9", "drained", eng_valid_o, 0);
    clr_txc_i = 1; tick();
  endtask

  task automatic t_clear_busy();
    wr2(16'hC2C1);
    tick();
    wr1(8'hC3);
    eng_start_i = 1; tick();
    clear_i = 1; tick();
    chk("R10", "in-flight kept", eng_valid_o, 1);
    chk("R10", "in-flight byte", eng_byte_o, 16'hC1);
    chk("R10", "queue flushed", lvl_ok_o, 1);
    chk("R10", "no txc in flight", txc_sts_o, 0);
    tick();
    chk("R10", "still in flight", eng_byte_o, 16'hC1);
    eng_done_i = 1; tick();
    chk("R10", "done after clear", eng_valid_o, 0);
    chk("R10", "txc after in-flight", txc_irq_o, 1);
    tick();
    chk("R10", "flushed stay gone", eng_valid_o, 0);
    clr_txc_i = 1; tick();
  endtask

  task automatic t_clear_idle();
    wr1(8'hD1);
    tick();
    wr1(8'hD2);
    clear_i = 1; tick();
    chk("R10", "unstarted dropped", eng_valid_o, 0);
    tick();
    chk("R10", "queued dropped", eng_valid_o, 0);
    chk("R10", "no txc irq", txc_irq_o, 0);
    chk("R10", "no txc sts", txc_sts_o, 0);
  endtask

  task automatic t_clear_write();
    clear_i = 1; wr_single_i = 1; wr_double_i = 1; wr_data_i = 16'hE2E1; tick();
    chk("R11", "stored after flush", lvl_ok_o, 0);
    chk("R11", "no ovf", ovf_irq_o, 0);
    tick();
    chk("R3", "double wins low", eng_byte_o, 16'hE1);
    send();
    chk("R3", "double wins high", eng_byte_o, 16'hE2);
    send();
    chk("R11", "drained", eng_valid_o, 0);
    chk("R9", "txc after drain", txc_sts_o, 1);
  endtask

  initial begin
    rst_n = 0; wr_single_i = 0; wr_double_i = 0; clear_i = 0; lvl_half_i = 0;
    clr_txc_i = 0; clr_ovf_i = 0; eng_start_i = 0; eng_done_i = 0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) tick();
    t_reset();
    t_single();
    t_double();
    t_partial();
    t_done_write();
    t_clear_busy();
    t_clear_idle();
    t_clear_write();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule